// File: doc/BRIEF.md
# Synchronized Shadow Register Update Controller

This block lets a fast-clocked core take new control settings in one atomic step at a fixed, predictable moment. Software or a host loads new values into a bank of staging registers through a plain parallel write port. Nothing reaches the core until an external update strobe is seen. That strobe is sampled in a slow synchronization domain, formed by dividing the system clock by four. All staged words then move into the active bank together, in a single system-clock cycle.

The synchronization domain is not a separate clock. A two-bit counter on the system clock produces a one-cycle enable, and every synchronization-domain flop uses it. A copy of the divided clock is driven out so that external logic can time the strobe against it, and a gating input can silence that copy. The profile-select bits and the keying input are registered in the same domain before they reach the core. When the active control word selects external shaped keying, the amplitude word from the active bank drives the datapath scale factor. Otherwise the scale is held at full scale.

Top module: `shadow_sync_ctrl`

## Requirements
- R1: The system clock is divided by exactly four. A counter that clears at reset advances every cycle. `sync_clk_o` is high in the two cycles where the counter is 2 or 3. The synchronization enable is the cycle where the counter is 1, so domain flops update on the same edge where `sync_clk_o` rises.
- R2: While `sync_off` is 1, `sync_clk_o` is 0. The divider and the sampling keep running.
- R3: `upd_strobe` is looked at only on synchronization enables. A high level that starts and ends between two enables produces no transfer.
- R4: A strobe sample of 1 that follows a sample of 0 gives `xfer_o` high for exactly one system cycle: the cycle right after that enable.
- R5: A strobe held high across many samples gives only one transfer. Another transfer needs at least one sample of 0 first.
- R6: In the cycle after `xfer_o` is high, every active register takes its staged value at once. At all other times the active bank holds its value.
- R7: A staging write in the same cycle that `xfer_o` is high is not part of that transfer. The previous staged value is applied, and the new one is kept for the next transfer.
- R8: `prof_o` and `key_o` take `prof_sel_i` and `key_i` on synchronization enables only, and hold between them.
- R9: Register 0 is the control word and register 1 holds the amplitude word in its low ASF_W bits. When active control bit 25 is 1 and bit 24 is 0, `ext_keying_o` is 1 and `scale_o` equals the active amplitude word. In every other case `ext_keying_o` is 0 and `scale_o` is all ones.
- R10: Reset clears the counter, the strobe history, the staging bank and the active bank. No transfer occurs while the strobe stays low.
- R11: `wr_en` with `wr_addr` and `wr_data` writes one staging register. The value reaches `act_bank_o` only after a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Staging register write enable |
| wr_addr | input | AW | Staging register index |
| wr_data | input | REG_W | Staging write data |
| upd_strobe | input | 1 | External update strobe |
| prof_sel_i | input | PROF_W | Profile-select input |
| key_i | input | 1 | Keying input |
| sync_off | input | 1 | Forces the divided clock output low |
| sync_clk_o | output | 1 | Divided-by-four clock for external timing |
| xfer_o | output | 1 | One-cycle transfer pulse |
| prof_o | output | PROF_W | Synchronized profile select |
| key_o | output | 1 | Synchronized keying input |
| act_bank_o | output | N_REGS*REG_W | Active bank; register i sits at bits i*REG_W upward |
| scale_o | output | ASF_W | Datapath amplitude scale factor |
| ext_keying_o | output | 1 | External shaped keying is selected |

## Verification
The bench places a short strobe pulse between two sampling enables. A design that samples on every system cycle would transfer on it. It holds the strobe high for many sync periods, which catches a level-triggered transfer that fires again and again. It also writes to staging in the very cycle of the transfer pulse: an ordering mistake would let the new value slip into that transfer. Finally it walks every combination of the two keying-mode bits, where a wrong decode would pass the amplitude word through in the automatic or off modes.

// File: rtl/shadow_sync_pkg.sv
package shadow_sync_pkg;
    localparam int DIV_W        = 2;   // divide-by-four counter width
    localparam int EXT_KEY_BIT  = 25;  // must be 1 for external keying
    localparam int AUTO_KEY_BIT = 24;  // must be 0 for external keying
endpackage

// File: rtl/sync_divider.sv
module sync_divider
    import shadow_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_off,
    output logic tick_o,
    output logic sync_clk_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // enable in the cycle before the output clock rises
    assign tick_o     = (st_q.cnt == DIV_W'(1));
    assign sync_clk_o = st_q.cnt[DIV_W-1] & ~sync_off;
endmodule

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int PROF_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              upd_strobe,
    input  logic [PROF_W-1:0] prof_in,
    input  logic              key_in,
    output logic              xfer_o,
    output logic [PROF_W-1:0] prof_o,
    output logic              key_o
);
    typedef struct packed {
        logic              smp;
        logic              xfer;
        logic [PROF_W-1:0] prof;
        logic              key;
    } smp_st_t;

    smp_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.xfer = 1'b0;
        if (tick) begin
            st_d.smp  = upd_strobe;
            st_d.xfer = upd_strobe & ~st_q.smp;
            st_d.prof = prof_in;
            st_d.key  = key_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign xfer_o = st_q.xfer;
    assign prof_o = st_q.prof;
    assign key_o  = st_q.key;
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank #(
    parameter int N_REGS = 4,
    parameter int REG_W  = 32,
    localparam int AW    = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [REG_W-1:0]        wr_data,
    input  logic                    xfer,
    output logic [N_REGS*REG_W-1:0] act_o
);
    typedef struct packed {
        logic [N_REGS-1:0][REG_W-1:0] stage;
        logic [N_REGS-1:0][REG_W-1:0] act;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // the transfer reads the staging bank as it was before this cycle's write
        if (xfer) st_d.act = st_q.stage;
        for (int i = 0; i < N_REGS; i++) begin
            if (wr_en && (wr_addr == AW'(i))) st_d.stage[i] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o = st_q.act;
endmodule

// File: rtl/scale_select.sv
module scale_select
    import shadow_sync_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int ASF_W = 14
) (
    input  logic [REG_W-1:0] ctrl_word,
    input  logic [REG_W-1:0] amp_word,
    output logic [ASF_W-1:0] scale_o,
    output logic             ext_keying_o
);
    logic             ext_d;
    logic [ASF_W-1:0] scale_d;

    always_comb begin
        ext_d   = ctrl_word[EXT_KEY_BIT] & ~ctrl_word[AUTO_KEY_BIT];
        scale_d = ext_d ? amp_word[ASF_W-1:0] : {ASF_W{1'b1}};
    end

    assign scale_o      = scale_d;
    assign ext_keying_o = ext_d;
endmodule

// File: rtl/shadow_sync_ctrl.sv
module shadow_sync_ctrl #(
    parameter int N_REGS   = 4,
    parameter int REG_W    = 32,
    parameter int ASF_W    = 14,
    parameter int PROF_W   = 2,
    parameter int CTRL_IDX = 0,
    parameter int AMP_IDX  = 1,
    localparam int AW      = (N_REGS > 1) ? $clog2(N_REGS) : 1,
    localparam int BANK_W  = N_REGS * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              upd_strobe,
    input  logic [PROF_W-1:0] prof_sel_i,
    input  logic              key_i,
    input  logic              sync_off,
    output logic              sync_clk_o,
    output logic              xfer_o,
    output logic [PROF_W-1:0] prof_o,
    output logic              key_o,
    output logic [BANK_W-1:0] act_bank_o,
    output logic [ASF_W-1:0]  scale_o,
    output logic              ext_keying_o
);
    logic tick;

    sync_divider u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_off   (sync_off),
        .tick_o     (tick),
        .sync_clk_o (sync_clk_o)
    );

    strobe_sync #(.PROF_W(PROF_W)) u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .upd_strobe (upd_strobe),
        .prof_in    (prof_sel_i),
        .key_in     (key_i),
        .xfer_o     (xfer_o),
        .prof_o     (prof_o),
        .key_o      (key_o)
    );

    shadow_bank #(.N_REGS(N_REGS), .REG_W(REG_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .xfer    (xfer_o),
        .act_o   (act_bank_o)
    );

    scale_select #(.REG_W(REG_W), .ASF_W(ASF_W)) u_scale (
        .ctrl_word    (act_bank_o[CTRL_IDX*REG_W +: REG_W]),
        .amp_word     (act_bank_o[AMP_IDX*REG_W +: REG_W]),
        .scale_o      (scale_o),
        .ext_keying_o (ext_keying_o)
    );
endmodule

// File: rtl/shadow_sync_chk.sv
module shadow_sync_chk #(
    parameter int BANK_W = 128,
    parameter int PROF_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              sync_off,
    input logic              sync_clk_o,
    input logic              upd_strobe,
    input logic              xfer_o,
    input logic [BANK_W-1:0] act_bank_o,
    input logic [PROF_W-1:0] prof_o,
    input logic              key_o
);
    // R1: the output clock rises right after each enable unless gated
    p_div_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (sync_clk_o || sync_off));

    // R3: a pulse only follows an enable that saw the strobe high
    p_sampled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |-> ($past(tick) && $past(upd_strobe)));

    // R4: the pulse lasts one cycle
    p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |=> !xfer_o);

    // R6: the active bank changes only after a pulse
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_o |=> $stable(act_bank_o));

    // R8: synchronized inputs move only on enables
    p_sync_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(prof_o) && $stable(key_o)));
endmodule

bind shadow_sync_ctrl shadow_sync_chk #(.BANK_W(BANK_W), .PROF_W(PROF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .sync_off   (sync_off),
    .sync_clk_o (sync_clk_o),
    .upd_strobe (upd_strobe),
    .xfer_o     (xfer_o),
    .act_bank_o (act_bank_o),
    .prof_o     (prof_o),
    .key_o      (key_o)
);

// File: tb/tb_shadow_sync_ctrl.sv
`timescale 1ns/1ps
module tb_shadow_sync_ctrl;
    localparam int N = 4;
    localparam int W = 32;
    localparam int AS = 14;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic          upd_strobe = 1'b0;
    logic [PW-1:0] prof_sel_i = '0;
    logic          key_i = 1'b0;
    logic          sync_off = 1'b0;
    logic          sync_clk_o, xfer_o, key_o, ext_keying_o;
    logic [PW-1:0] prof_o;
    logic [N*W-1:0] act_bank_o;
    logic [AS-1:0] scale_o;

    always #4 clk = ~clk;

    shadow_sync_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .upd_strobe(upd_strobe), .prof_sel_i(prof_sel_i),
        .key_i(key_i), .sync_off(sync_off), .sync_clk_o(sync_clk_o),
        .xfer_o(xfer_o), .prof_o(prof_o), .key_o(key_o),
        .act_bank_o(act_bank_o), .scale_o(scale_o), .ext_keying_o(ext_keying_o)
    );

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    bit done   = 0;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // behavioural reference model
    int       m_phase;
    bit       m_last, m_pulse, m_key;
    int       m_prof;
    logic [W-1:0] m_stage[N];
    logic [W-1:0] m_act[N];

    always @(posedge clk) begin
        bit fire;
        bit ext;
        if (!rst_n) begin
            m_phase = 0; m_last = 0; m_pulse = 0; m_key = 0; m_prof = 0;
            for (int i = 0; i < N; i++) begin m_stage[i] = '0; m_act[i] = '0; end
        end else begin
            if (m_pulse) for (int i = 0; i < N; i++) m_act[i] = m_stage[i];
            if (wr_en) m_stage[wr_addr] = wr_data;
            fire = (m_phase == 1) && upd_strobe && !m_last;
            if (m_phase == 1) begin
                m_last = upd_strobe; m_prof = prof_sel_i; m_key = key_i;
            end
            m_pulse = fire;
            m_phase = (m_phase + 1) % 4;
        end
        #2;
        chk("R1/R2 sync_clk_o", 64'(sync_clk_o), 64'((m_phase >= 2) && !sync_off));
        chk("R4 xfer_o", 64'(xfer_o), 64'(m_pulse));
        chk("R8 prof_o", 64'(prof_o), 64'(m_prof));
        chk("R8 key_o", 64'(key_o), 64'(m_key));
        for (int i = 0; i < N; i++)
            chk("R6 active register", 64'(act_bank_o[i*W +: W]), 64'(m_act[i]));
        ext = m_act[0][25] && !m_act[0][24];
        chk("R9 ext_keying_o", 64'(ext_keying_o), 64'(ext));
        chk("R9 scale_o", 64'(scale_o), ext ? 64'(m_act[1][AS-1:0]) : 64'(14'h3FFF));
        if (xfer_o) pulses++;
    end

    task automatic write_reg(input int a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_update();
        upd_strobe = 1'b1;
        repeat (10) @(negedge clk);
        upd_strobe = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic find_rise();
        logic prev;
        prev = sync_clk_o;
        @(negedge clk);
        while (!(sync_clk_o && !prev)) begin
            prev = sync_clk_o;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        int p0;
        logic [W-1:0] v;
        repeat (3) @(negedge clk);
        chk("R10 reset active bank", 64'(act_bank_o), 64'(0));
        chk("R10 reset pulse", 64'(xfer_o), 64'(0));
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R10 no pulse after reset", 64'(pulses), 64'(0));

        // R11: writes stay staged until a transfer
        write_reg(0, 32'h0000_1234);
        write_reg(1, 32'h0000_2ABC);
        write_reg(2, 32'hDEAD_BEEF);
        write_reg(3, 32'h0BAD_F00D);
        repeat (8) @(negedge clk);
        chk("R11 staged not yet active", 64'(act_bank_o[2*W +: W]), 64'(0));

        // R5: a long high strobe gives one transfer
        p0 = pulses;
        upd_strobe = 1'b1;
        repeat (40) @(negedge clk);
        upd_strobe = 1'b0;
        repeat (10) @(negedge clk);
        chk("R5 one pulse for long strobe", 64'(pulses - p0), 64'(1));
        chk("R11 reg2 active after update", 64'(act_bank_o[2*W +: W]), 64'(32'hDEAD_BEEF));

        // R3: a pulse between two enables is not seen
        p0 = pulses;
        find_rise();
        upd_strobe = 1'b1;
        repeat (3) @(negedge clk);
        upd_strobe = 1'b0;
        repeat (12) @(negedge clk);
        chk("R3 short strobe ignored", 64'(pulses - p0), 64'(0));

        // R7: a write in the pulse cycle waits for the next transfer
        write_reg(2, 32'h1111_2222);
        find_rise();
        upd_strobe = 1'b1;
        while (!xfer_o) @(negedge clk);
        write_reg(2, 32'h3333_4444);
        upd_strobe = 1'b0;
        repeat (10) @(negedge clk);
        chk("R7 coincident write excluded", 64'(act_bank_o[2*W +: W]), 64'(32'h1111_2222));
        do_update();
        chk("R7 coincident write applied later", 64'(act_bank_o[2*W +: W]), 64'(32'h3333_4444));

        // R9: every mode-bit combination
        for (int m = 0; m < 4; m++) begin
            write_reg(0, 32'(m) << 24);
            write_reg(1, 32'(16'h0155 + m));
            do_update();
            chk("R9 ext mode decode", 64'(ext_keying_o), 64'(m == 2));
            chk("R9 scale value", 64'(scale_o),
                (m == 2) ? 64'(14'h0157) : 64'(14'h3FFF));
        end

        // R2: gated output clock
        sync_off = 1'b1;
        v = '0;
        repeat (12) begin @(negedge clk); v = v | W'(sync_clk_o); end
        chk("R2 sync_clk_o gated", 64'(v), 64'(0));
        sync_off = 1'b0;

        // R8 and all: mixed random traffic checked by the model
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            prof_sel_i = PW'($urandom_range(0, 3));
            key_i      = 1'($urandom_range(0, 1));
            wr_en      = ($urandom_range(0, 3) == 0);
            wr_addr    = 2'($urandom_range(0, 3));
            wr_data    = $urandom();
            if ($urandom_range(0, 5) == 0) upd_strobe = ~upd_strobe;
            sync_off   = ($urandom_range(0, 9) == 0);
        end
        wr_en = 1'b0;
        upd_strobe = 1'b0;
        repeat (10) @(negedge clk);
        summary();
    end
endmodule